// File: doc/BRIEF.md
# MMIO Access Spacing Delay Unit

This block sits on the request path between a bus gasket and a register block. It enforces a programmable minimum spacing after a memory-mapped write, both in front of a later read and in front of a later write. Each of the two spacings is switched on or off by its own control input. Requests travel on a valid/ready channel and carry a read/write flag, an address, write data and a marker for the first half of a split 64-bit write.

A 64-bit write arrives as two consecutive 32-bit writes, and the first of the two is flagged with `reqPairHead`. The second half is never held back by the write spacing. The spacing for both reads and writes is timed from the second half. The gap is a down-counter. It is loaded from `delayCount` whenever a write that completes an access is accepted, and a request type that the gap applies to is held with its ready low until the counter reaches zero.

Top module: `mmio_gap_unit`

## Requirements
- R1: A request is forwarded only when it is not held off. While it is held, `outValid` and `reqReady` are both 0. Otherwise `outValid` follows `reqValid` and `reqReady` follows `outReady`, and the address, data and write flag pass through unchanged.
- R2: With `rawDisable` = 0, a read is accepted no earlier than D+1 clock edges after the edge that accepted the last completing write, where D is the `delayCount` value at that write's acceptance.
- R3: With `rawDisable` = 1, a read is accepted on the first edge it is presented with `outReady` = 1, whatever writes came before.
- R4: With `wawEnable` = 1, a write is accepted no earlier than D+1 edges after the last completing write.
- R5: With `wawEnable` = 0, writes are accepted back to back, with no added cycles.
- R6: The write following an accepted write that had `reqPairHead` = 1 is exempt from the write gap. The head write does not start a gap.
- R7: For a split pair, the read gap and the write gap are both timed from the acceptance of the second half.
- R8: A `delayCount` of 0 adds no cycles, even when a gap is enabled.
- R9: After reset no gap is pending, and a request is accepted at once.
- R10: The gap length is captured when the write is accepted. Later changes of `delayCount` do not alter a gap that is already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid from the gasket |
| reqReady | output | 1 | Request accepted this cycle when high together with reqValid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqPairHead | input | 1 | 1 = first 32-bit half of a split 64-bit write |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write data |
| outValid | output | 1 | Forwarded request valid to the register block |
| outReady | input | 1 | Register block can take a request |
| outWrite | output | 1 | Forwarded read/write flag |
| outAddr | output | ADDR_W | Forwarded address |
| outWdata | output | DATA_W | Forwarded write data |
| rawDisable | input | 1 | 1 = reads are not spaced after writes |
| wawEnable | input | 1 | 1 = writes are spaced after writes |
| delayCount | input | CNT_W | Gap length in clock cycles |

## Verification
On every cycle the assertions check, against an independent gap counter in the checker, that no read or write is accepted inside an active gap, and that a request is never held once its gap is over. They also check that the second half of a pair passes without stalling and that each accepted request is handed downstream in the same cycle. The exact acceptance edge of each request is shown only by the directed scenarios. These cover the split pair timed from its second half, a gap length held after `delayCount` changes, back-to-back writes with the gap disabled, and the held payload under backpressure.

// File: rtl/mmio_gap_pkg.sv
package mmio_gap_pkg;
  typedef struct packed {
    logic load;     // start a new gap from delayCount
    logic dec;      // count the running gap down
    logic pairSet;  // first half of a split write accepted
    logic pairClr;  // completing write accepted
  } gapStrobes_t;
endpackage

// File: rtl/mmio_gap_ctrl.sv
module mmio_gap_ctrl
  import mmio_gap_pkg::*;
(
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqPairHead,
  input  logic        outReady,
  input  logic        rawDisable,
  input  logic        wawEnable,
  input  logic        gapDone,
  input  logic        pairOpen,
  output logic        reqReady,
  output logic        outValid,
  output gapStrobes_t strb
);
  logic readHeld;
  logic writeHeld;
  logic holdOff;
  logic accept;

  always_comb begin
    readHeld  = !reqWrite && !rawDisable && !gapDone;
    writeHeld = reqWrite && wawEnable && !gapDone && !pairOpen;
    holdOff   = readHeld || writeHeld;
    outValid  = reqValid && !holdOff;
    reqReady  = outReady && !holdOff;
    accept    = reqValid && reqReady;
    strb.load    = accept && reqWrite && !reqPairHead;
    strb.pairClr = accept && reqWrite && !reqPairHead;
    strb.pairSet = accept && reqWrite && reqPairHead;
    strb.dec     = !gapDone && !strb.load;
  end
endmodule

// File: rtl/mmio_gap_dp.sv
module mmio_gap_dp
  import mmio_gap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  gapStrobes_t       strb,
  input  logic [CNT_W-1:0]  delayCount,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              gapDone,
  output logic              pairOpen,
  output logic              outWrite,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outWdata
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= CNT_ZERO;
    end else if (strb.load) begin
      gapCnt <= delayCount;
    end else if (strb.dec) begin
      gapCnt <= gapCnt - CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pairOpen <= 1'b0;
    end else if (strb.pairSet) begin
      pairOpen <= 1'b1;
    end else if (strb.pairClr) begin
      pairOpen <= 1'b0;
    end
  end

  always_comb begin
    gapDone  = (gapCnt == CNT_ZERO);
    outWrite = reqWrite;
    outAddr  = reqAddr;
    outWdata = reqWdata;
  end
endmodule

// File: rtl/mmio_gap_unit.sv
module mmio_gap_unit
  import mmio_gap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqPairHead,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              outValid,
  input  logic              outReady,
  output logic              outWrite,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outWdata,
  input  logic              rawDisable,
  input  logic              wawEnable,
  input  logic [CNT_W-1:0]  delayCount
);
  gapStrobes_t strb;
  logic        gapDone;
  logic        pairOpen;

  mmio_gap_ctrl uCtrl (
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .reqPairHead (reqPairHead),
    .outReady    (outReady),
    .rawDisable  (rawDisable),
    .wawEnable   (wawEnable),
    .gapDone     (gapDone),
    .pairOpen    (pairOpen),
    .reqReady    (reqReady),
    .outValid    (outValid),
    .strb        (strb)
  );

  mmio_gap_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .delayCount (delayCount),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .gapDone    (gapDone),
    .pairOpen   (pairOpen),
    .outWrite   (outWrite),
    .outAddr    (outAddr),
    .outWdata   (outWdata)
  );
endmodule

// File: rtl/mmio_gap_checker.sv
module mmio_gap_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             reqWrite,
  input logic             reqPairHead,
  input logic             outValid,
  input logic             outReady,
  input logic             rawDisable,
  input logic             wawEnable,
  input logic [CNT_W-1:0] delayCount
);
  // Independent model of the remaining gap, built from port activity only.
  logic [CNT_W-1:0] leftCnt;
  logic             headSeen;
  logic             fire;

  assign fire = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leftCnt  <= '0;
      headSeen <= 1'b0;
    end else begin
      if (fire && reqWrite && !reqPairHead) leftCnt <= delayCount;
      else if (leftCnt != '0) leftCnt <= leftCnt - 1'b1;
      if (fire && reqWrite) headSeen <= reqPairHead;
    end
  end

  assert_handshake_pass_R1: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> (outValid && outReady));

  assert_read_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fire && !reqWrite && !rawDisable) |-> (leftCnt == '0));

  assert_read_free_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && rawDisable && outReady) |-> reqReady);

  assert_write_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fire && reqWrite && wawEnable && !headSeen) |-> (leftCnt == '0));

  assert_write_free_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !wawEnable && outReady) |-> reqReady);

  assert_pair_exempt_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && headSeen && outReady) |-> reqReady);

  assert_no_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && outReady && leftCnt == '0) |-> reqReady);
endmodule

bind mmio_gap_unit mmio_gap_checker #(.CNT_W(CNT_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .reqWrite    (reqWrite),
  .reqPairHead (reqPairHead),
  .outValid    (outValid),
  .outReady    (outReady),
  .rawDisable  (rawDisable),
  .wawEnable   (wawEnable),
  .delayCount  (delayCount)
);

// File: tb/tb_mmio_gap_unit.sv
module tb_mmio_gap_unit;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqPairHead = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic outReady = 1'b1, rawDisable = 1'b0, wawEnable = 1'b0;
  logic [CNT_W-1:0] delayCount = '0;
  logic reqReady, outValid, outWrite;
  logic [ADDR_W-1:0] outAddr;
  logic [DATA_W-1:0] outWdata;

  int edgeCount = 0;
  int total = 0;
  int fails = 0;
  // reference model state
  int lastEnd = -1000;
  int lastD = 0;
  bit pairOpen = 0;

  always #10 clk = ~clk;
  always @(posedge clk) edgeCount <= edgeCount + 1;

  mmio_gap_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqPairHead(reqPairHead), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .outValid(outValid), .outReady(outReady),
    .outWrite(outWrite), .outAddr(outAddr), .outWdata(outWdata),
    .rawDisable(rawDisable), .wawEnable(wawEnable), .delayCount(delayCount)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expectedEdge(input bit w, input int start);
    int e = start;
    if (!w && !rawDisable && lastEnd + lastD + 1 > e) e = lastEnd + lastD + 1;
    if (w && wawEnable && !pairOpen && lastEnd + lastD + 1 > e) e = lastEnd + lastD + 1;
    return e;
  endfunction

  // Presents one request, waits for acceptance, returns the accepting edge and the model's expectation.
  task automatic doReq(input bit w, input bit head, output int acc, output int exp);
    int start;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqPairHead = head;
    reqAddr = ADDR_W'(edgeCount * 4); reqWdata = DATA_W'(edgeCount);
    start = edgeCount + 1;
    exp = expectedEdge(w, start);
    forever begin
      #1;
      if (reqReady) break;
      @(negedge clk);
    end
    acc = edgeCount + 1;
    @(posedge clk);
    #1 reqValid = 1'b0;
    if (w) begin
      if (head) pairOpen = 1;
      else begin pairOpen = 0; lastEnd = acc; lastD = int'(delayCount); end
    end
  endtask

  task automatic testReset;
    int a, e;
    rawDisable = 0; delayCount = 7;
    @(negedge clk);
    check("R9 ready after reset", int'(reqReady), 1);
    doReq(0, 0, a, e);
    check("R9 read immediate after reset", a - e, 0);
  endtask

  task automatic testReadGap;
    int a, e, w;
    rawDisable = 0; wawEnable = 0; delayCount = 5;
    doReq(1, 0, w, e);
    doReq(0, 0, a, e);
    check("R2 read spacing after write", a - w, 6);
  endtask

  task automatic testReadFree;
    int a, e, w;
    rawDisable = 1; delayCount = 9;
    doReq(1, 0, w, e);
    doReq(0, 0, a, e);
    check("R3 read not held with gap disabled", a - w, 1);
    rawDisable = 0;
  endtask

  task automatic testWriteFree;
    int a, e, w;
    wawEnable = 0; delayCount = 8;
    doReq(1, 0, w, e);
    doReq(1, 0, a, e);
    check("R5 writes back to back", a - w, 1);
  endtask

  task automatic testWriteGap;
    int a, e, w;
    wawEnable = 1; delayCount = 4;
    doReq(1, 0, w, e);
    doReq(1, 0, a, e);
    check("R4 write spacing after write", a - w, 5);
    check("R4 model agrees", a, e);
    wawEnable = 0;
  endtask

  task automatic testSplitPair;
    int h, s, r, e, w2;
    wawEnable = 1; rawDisable = 0; delayCount = 3;
    doReq(1, 1, h, e);
    check("R6 head write spaced from prior", h, e);
    doReq(1, 0, s, e);
    check("R6 second half no gap", s - h, 1);
    doReq(0, 0, r, e);
    check("R7 read timed from second half", r - s, 4);
    doReq(1, 1, h, e);
    doReq(1, 0, s, e);
    doReq(1, 0, w2, e);
    check("R7 write timed from second half", w2 - s, 4);
    wawEnable = 0;
  endtask

  task automatic testZeroDelay;
    int a, e, w;
    wawEnable = 1; rawDisable = 0; delayCount = 0;
    doReq(1, 0, w, e);
    doReq(1, 0, a, e);
    check("R8 zero delay write", a - w, 1);
    doReq(0, 0, a, e);
    check("R8 zero delay read", a - w, 2);
    wawEnable = 0;
  endtask

  task automatic testLatched;
    int a, e, w;
    rawDisable = 0; delayCount = 6;
    doReq(1, 0, w, e);
    delayCount = 1;
    doReq(0, 0, a, e);
    check("R10 gap kept after count change", a - w, 7);
  endtask

  task automatic testBackpressure;
    rawDisable = 1;
    @(negedge clk);
    outReady = 0; reqValid = 1; reqWrite = 0; reqPairHead = 0;
    reqAddr = 16'hBEE0; reqWdata = 32'h1234_5678;
    for (int i = 0; i < 3; i++) begin
      #1;
      check("R1 ready low under backpressure", int'(reqReady), 0);
      @(negedge clk);
    end
    #1;
    check("R1 valid forwarded", int'(outValid), 1);
    check("R1 address passed", int'(outAddr), 16'hBEE0);
    check("R1 write flag passed", int'(outWrite), 0);
    outReady = 1;
    #1;
    check("R1 ready follows downstream", int'(reqReady), 1);
    @(posedge clk);
    #1 reqValid = 0;
    // held case: read inside an active gap is not forwarded
    rawDisable = 0; delayCount = 5;
    begin
      int w, e;
      doReq(1, 0, w, e);
    end
    @(negedge clk);
    reqValid = 1; reqWrite = 0;
    #1;
    check("R1 outValid low while held", int'(outValid), 0);
    check("R1 reqReady low while held", int'(reqReady), 0);
    reqValid = 0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testReadGap();
    testReadFree();
    testWriteFree();
    testWriteGap();
    testSplitPair();
    testZeroDelay();
    testLatched();
    testBackpressure();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", edgeCount, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule